// File: doc/BRIEF.md
# Per-Transfer Scatter-Gather Address Translator

This block translates device-side addresses for long, linear transfers. It holds a small number of transfer slots. Each slot describes one transfer: a page-aligned window of device addresses, how many pages the window spans, and a short ordered list of physical page numbers. A device address that falls inside a slot's window is rewritten to the matching physical page. The byte offset inside the 4 KiB page is kept unchanged. An address that no valid slot covers returns a fault instead of an address.

Privileged software programs and retires slots one at a time through a small configuration port. There is no translation cache shared between transfers. When a transfer finishes, software flushes only that slot, and every other transfer keeps translating without a break. A lookup is answered one clock after it is presented.

Top module: `sgx_xlat`

## Requirements
- R1: After reset every slot is invalid, `rsp_valid` is low, and any lookup faults.
- R2: A response (`rsp_valid` high) appears exactly one clock after each cycle with `req_valid` high, and in no other cycle.
- R3: For an address in a valid slot with page index k = (req_addr >> 12) - base_page and k < count, `rsp_paddr` = {entry[k], req_addr[11:0]} and `rsp_fault` = 0.
- R4: An address below a slot's base, or whose page index is at or beyond that slot's count, is not translated by that slot. When no slot translates an address, `rsp_fault` = 1 and `rsp_paddr` = 0.
- R5: Flushing one slot makes its addresses fault afterwards, while the other slots keep their translations.
- R6: A lookup presented in the same cycle as a flush of a slot treats that slot as already invalid.
- R7: When several valid slots cover an address, the lowest-numbered slot supplies the translation.
- R8: Configuration commands with `cfg_priv` = 0 change nothing.
- R9: A setup count above 16 is treated as 16. A count of 0 makes the slot translate no address.
- R10: Opcodes on `cfg_op`: 1 = setup (base page `cfg_data[31:12]`, count `cfg_data[4:0]`, slot becomes valid, entries kept); 2 = entry write (entry `cfg_idx` gets page number `cfg_data[31:12]`); 3 = flush (slot becomes invalid); 0 = no operation. Entries reset to page number 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_op | input | 2 | Configuration opcode |
| cfg_priv | input | 1 | Command issued from the privileged level |
| cfg_slot | input | 2 | Target slot of the command |
| cfg_idx | input | 4 | Entry index for entry writes |
| cfg_data | input | 32 | Command payload |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Device address to translate |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_fault | output | 1 | Address not translated |
| rsp_paddr | output | 32 | Translated physical address |

## Verification
Lookups are aimed at the first, middle and last page of a window, and at the pages just before and just after it. This separates a wrong index from a bad bound check. Overlapping windows show whether priority follows slot number or an accidental later-wins mux. A lookup issued together with a flush, with a lower slot that covers the same address, shows whether the flush masks the slot in the same cycle. Commands without privilege, a saturating count and a zero count check that the stored state stays as it should. Each of these is observed through later lookups.

// File: rtl/sgx_pkg.sv
package sgx_pkg;
    localparam int ADDR_W  = 32;
    localparam int PAGE_SH = 12;
    localparam int NSLOT   = 4;
    localparam int NPAGE   = 16;
    localparam int PN_W    = ADDR_W - PAGE_SH;
    localparam int IDX_W   = $clog2(NPAGE);
    localparam int CNT_W   = $clog2(NPAGE) + 1;
    localparam int SLOT_W  = $clog2(NSLOT);

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_SETUP = 2'd1,
        OP_ENTRY = 2'd2,
        OP_FLUSH = 2'd3
    } cfg_op_e;

    typedef struct packed {
        logic              fault;
        logic [ADDR_W-1:0] paddr;
    } rsp_t;

    function automatic logic [CNT_W-1:0] clamp_count(input logic [CNT_W-1:0] c);
        if (c > CNT_W'(NPAGE)) return CNT_W'(NPAGE);
        return c;
    endfunction
endpackage

// File: rtl/sgx_slot.sv
module sgx_slot
    import sgx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  cfg_op_e          op,
    input  logic [IDX_W-1:0] idx,
    input  logic [PN_W-1:0]  page_in,
    input  logic [CNT_W-1:0] count_in,
    input  logic [PN_W-1:0]  look_pn,
    output logic             hit,
    output logic [PN_W-1:0]  ppn
);
    logic             valid_q;
    logic [PN_W-1:0]  base_q;
    logic [CNT_W-1:0] count_q;
    logic [PN_W-1:0]  ent_q [NPAGE];
    logic [PN_W-1:0]  diff;
    logic             flushing;

    assign flushing = sel && (op == OP_FLUSH);
    assign diff     = look_pn - base_q;
    assign hit      = valid_q && !flushing && (look_pn >= base_q) &&
                      (diff < PN_W'(count_q));
    assign ppn      = ent_q[diff[IDX_W-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            base_q  <= '0;
            count_q <= '0;
            for (int i = 0; i < NPAGE; i++) ent_q[i] <= '0;
        end else if (sel) begin
            case (op)
                OP_SETUP: begin
                    valid_q <= 1'b1;
                    base_q  <= page_in;
                    count_q <= clamp_count(count_in);
                end
                OP_ENTRY: ent_q[idx] <= page_in;
                OP_FLUSH: valid_q <= 1'b0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sgx_pick.sv
module sgx_pick
    import sgx_pkg::*;
(
    input  logic [NSLOT-1:0] hit,
    input  logic [PN_W-1:0]  ppn [NSLOT],
    output logic [NSLOT-1:0] sel,
    output logic             any,
    output logic [PN_W-1:0]  ppn_out
);
    always_comb begin
        sel     = '0;
        any     = 1'b0;
        ppn_out = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (hit[i] && !any) begin
                sel[i]  = 1'b1;
                any     = 1'b1;
                ppn_out = ppn[i];
            end
        end
    end
endmodule

// File: rtl/sgx_xlat.sv
module sgx_xlat
    import sgx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_op,
    input  logic              cfg_priv,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_data,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [ADDR_W-1:0] rsp_paddr
);
    cfg_op_e          op;
    logic [NSLOT-1:0] hit;
    logic [NSLOT-1:0] sel_oh;
    logic [PN_W-1:0]  slot_ppn [NSLOT];
    logic [PN_W-1:0]  ppn_sel;
    logic             any_hit;
    logic [PN_W-1:0]  look_pn;
    rsp_t             rsp_d, rsp_q;
    logic             valid_q;
    logic             unused_cfg;

    assign op         = cfg_op_e'(cfg_op);
    assign look_pn    = req_addr[ADDR_W-1:PAGE_SH];
    assign unused_cfg = ^cfg_data[PAGE_SH-1:CNT_W];

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        sgx_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .sel      (cfg_priv && (op != OP_NONE) && (cfg_slot == SLOT_W'(s))),
            .op       (op),
            .idx      (cfg_idx),
            .page_in  (cfg_data[ADDR_W-1:PAGE_SH]),
            .count_in (cfg_data[CNT_W-1:0]),
            .look_pn  (look_pn),
            .hit      (hit[s]),
            .ppn      (slot_ppn[s])
        );
    end

    sgx_pick u_pick (
        .hit     (hit),
        .ppn     (slot_ppn),
        .sel     (sel_oh),
        .any     (any_hit),
        .ppn_out (ppn_sel)
    );

    always_comb begin
        rsp_d.fault = !any_hit;
        rsp_d.paddr = any_hit ? {ppn_sel, req_addr[PAGE_SH-1:0]} : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            rsp_q   <= '0;
        end else begin
            valid_q <= req_valid;
            if (req_valid) rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = valid_q;
    assign rsp_fault = rsp_q.fault;
    assign rsp_paddr = rsp_q.paddr;
endmodule

// File: rtl/sgx_xlat_checker.sv
module sgx_xlat_checker
    import sgx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic [NSLOT-1:0]  sel
);
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R2
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_fault || rsp_paddr[PAGE_SH-1:0] == $past(req_addr[PAGE_SH-1:0]))); // R3
    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0)); // R4
    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel)); // R7
endmodule

bind sgx_xlat sgx_xlat_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_paddr (rsp_paddr),
    .sel       (sel_oh)
);

// File: tb/sgx_xlat_bench.sv
module sgx_xlat_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_op = 2'd0;
    logic        cfg_priv = 1'b0;
    logic [1:0]  cfg_slot = 2'd0;
    logic [3:0]  cfg_idx = 4'd0;
    logic [31:0] cfg_data = 32'd0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = 32'd0;
    logic        rsp_valid, rsp_fault;
    logic [31:0] rsp_paddr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic        fault;
        logic [31:0] paddr;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    sgx_xlat u_sgx_xlat (
        .clk(clk), .rst(rst), .cfg_op(cfg_op), .cfg_priv(cfg_priv),
        .cfg_slot(cfg_slot), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
    );

    // monitor: compares each response against the queue head
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R2: response with nothing expected (fault=%0b paddr=%h)", rsp_fault, rsp_paddr);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (rsp_fault !== e.fault || rsp_paddr !== e.paddr) begin
                    errors++;
                    $display("FAIL %s: got fault=%0b paddr=%h, expected fault=%0b paddr=%h",
                             e.tag, rsp_fault, rsp_paddr, e.fault, e.paddr);
                end
            end
        end
    end

    task automatic cfg(input logic [1:0] op, input logic [1:0] slot, input logic [3:0] idx,
                       input logic [31:0] data, input logic priv);
        cfg_op = op; cfg_slot = slot; cfg_idx = idx; cfg_data = data; cfg_priv = priv;
        @(negedge clk);
        cfg_op = 2'd0; cfg_priv = 1'b0;
    endtask

    task automatic look(input logic [31:0] addr, input logic f, input logic [31:0] pa, input string tag);
        q.push_back('{fault: f, paddr: pa, tag: tag});
        req_valid = 1'b1; req_addr = addr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic flush_and_look(input logic [1:0] slot, input logic [31:0] addr,
                                  input logic f, input logic [31:0] pa, input string tag);
        q.push_back('{fault: f, paddr: pa, tag: tag});
        cfg_op = 2'd3; cfg_slot = slot; cfg_priv = 1'b1;
        req_valid = 1'b1; req_addr = addr;
        @(negedge clk);
        cfg_op = 2'd0; cfg_priv = 1'b0; req_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: rsp_valid=%0b expected 0", rsp_valid);
        end
        look(32'h0000_1000, 1'b1, 32'h0, "R1");

        // slot 0: base page 0x10, three pages
        cfg(2'd1, 2'd0, 4'd0, 32'h0001_0003, 1'b1); // R10 setup
        cfg(2'd2, 2'd0, 4'd0, 32'hAAAA_A000, 1'b1);
        cfg(2'd2, 2'd0, 4'd1, 32'h1234_5000, 1'b1);
        cfg(2'd2, 2'd0, 4'd2, 32'h0BEE_F000, 1'b1);
        look(32'h0001_0ABC, 1'b0, 32'hAAAA_AABC, "R3");
        look(32'h0001_1004, 1'b0, 32'h1234_5004, "R3");
        look(32'h0001_2FFF, 1'b0, 32'h0BEE_FFFF, "R3");
        look(32'h0001_3000, 1'b1, 32'h0, "R4");
        look(32'h0000_F000, 1'b1, 32'h0, "R4");

        // slot 1: count 31 saturates to 16
        cfg(2'd1, 2'd1, 4'd0, 32'h0002_001F, 1'b1);
        cfg(2'd2, 2'd1, 4'd15, 32'h5555_5000, 1'b1);
        look(32'h0002_F123, 1'b0, 32'h5555_5123, "R9");
        look(32'h0003_0000, 1'b1, 32'h0, "R9");

        // slot 2 overlaps slot 0 with four pages
        cfg(2'd1, 2'd2, 4'd0, 32'h0001_0004, 1'b1);
        cfg(2'd2, 2'd2, 4'd0, 32'h7777_7000, 1'b1);
        cfg(2'd2, 2'd2, 4'd3, 32'h6666_6000, 1'b1);
        look(32'h0001_0000, 1'b0, 32'hAAAA_A000, "R7");
        look(32'h0001_3010, 1'b0, 32'h6666_6010, "R7");

        // slot 3: zero count translates nothing
        cfg(2'd1, 2'd3, 4'd0, 32'h0004_0000, 1'b1);
        look(32'h0004_0000, 1'b1, 32'h0, "R9");

        // unprivileged commands are ignored
        cfg(2'd1, 2'd3, 4'd0, 32'h0005_0001, 1'b0);
        look(32'h0005_0000, 1'b1, 32'h0, "R8");
        cfg(2'd2, 2'd0, 4'd0, 32'h9999_9000, 1'b0);
        look(32'h0001_0000, 1'b0, 32'hAAAA_A000, "R8");
        cfg(2'd3, 2'd0, 4'd0, 32'h0, 1'b0);
        look(32'h0001_1000, 1'b0, 32'h1234_5000, "R8");

        // flush of slot 0 concurrent with a lookup: slot 2 must answer
        flush_and_look(2'd0, 32'h0001_0100, 1'b0, 32'h7777_7100, "R6");
        look(32'h0001_1000, 1'b0, 32'h0000_0000, "R5");
        look(32'h0002_F123, 1'b0, 32'h5555_5123, "R5");
        cfg(2'd3, 2'd2, 4'd0, 32'h0, 1'b1);
        look(32'h0001_0000, 1'b1, 32'h0, "R5");
        look(32'h0002_0000, 1'b0, 32'h0000_0000, "R5");

        // idle cycle: no response expected
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2: rsp_valid=%0b expected 0 on idle", rsp_valid);
        end
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R2: %0d responses missing, expected 0", q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule